// File: doc/BRIEF.md
# Host Attention Interrupt Controller

This block drives a level-sensitive interrupt line toward a host processor in a block-transfer style management mailbox. It keeps a small two-bit mask register: one bit lets the host enable the interrupt, and the other records that an interrupt is pending. The host writes this register to enable, disable or acknowledge. The management side reports three kinds of event: a response that is ready for the host, a request to set its attention flag, and a request to clear that flag. A reset strobe can be marked cold or warm.

The two attention flags are kept elsewhere. This block only samples their current levels: `b2h_atn` is the response-attention flag and `sms_atn` is the management-message flag. The interrupt line is the registered pending bit, so it has no glitches, and it changes one clock after the event that moves it. Every input event is a single-cycle strobe. The control pins are plain and have no handshake, because the block passes no data stream.

Top module: `bt_host_irq`

## Requirements
- R1: After `rst_n` is deasserted, `mask_rd` reads 0 and `irq` is 0. In the readback, bit 0 is the enable, bit 1 is the pending flag, and the upper bits read 0.
- R2: A host write with bit 0 set, made while the enable is 0, sets the enable. It also sets pending when `b2h_atn` or `sms_atn` is high, whatever `irq_use` and `irq_allow` are.
- R3: A host write with bit 0 clear, made while the enable is 1, clears both the enable and pending.
- R4: A host write with bit 1 set clears pending. This is applied after any enable change made by the same write. A write with bit 1 clear and bit 0 equal to the current enable changes nothing.
- R5: `rsp_done` sets pending only when `irq_use`, `irq_allow` and the enable are all 1 and pending is 0. Otherwise it has no effect.
- R6: `sms_set` has no effect while `sms_atn` is already 1. Otherwise it sets pending only when `sms_raise`, the enable, `irq_use` and `irq_allow` are all 1 and `b2h_atn` is 0.
- R7: `sms_clr` clears pending only when `sms_atn` is 1 and `b2h_atn` is 0. Otherwise it has no effect.
- R8: `rst_req` with `rst_cold`=1 clears the enable and pending. With `rst_cold`=0 it changes nothing.
- R9: When several events arrive in one cycle, only the highest-priority one acts, in this order: reset strobe, host write, `rsp_done`, `sms_set`, `sms_clr`.
- R10: `irq` equals the pending bit of the register. The register changes only on the clock edge that samples an event, and it is unaffected by changes on the attention levels alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe to the mask register |
| host_wdata | input | DATA_W | Host write data (bit 0 enable, bit 1 acknowledge) |
| rsp_done | input | 1 | Response-ready strobe from the management side |
| sms_set | input | 1 | Request to set management attention |
| sms_raise | input | 1 | Qualifies `sms_set`: an interrupt is wanted |
| sms_clr | input | 1 | Request to clear management attention |
| rst_req | input | 1 | Interface reset strobe |
| rst_cold | input | 1 | Marks `rst_req` as a cold reset |
| irq_allow | input | 1 | Global interrupt allow |
| irq_use | input | 1 | Configuration: interrupt line is wired |
| b2h_atn | input | 1 | Current response-attention level |
| sms_atn | input | 1 | Current management-attention level |
| irq | output | 1 | Level interrupt to the host |
| mask_rd | output | DATA_W | Mask register readback |

## Verification
The properties assume that every event input is a one-cycle strobe, sampled on a rising edge. Those that describe one event's effect hold only when no higher-priority strobe is active in the same cycle. The attention levels are taken as already stable at the edge. The bench changes all inputs on the falling edge, raises each strobe for exactly one cycle, and drives overlapping strobes only in the scenario written for the priority order.

// File: rtl/bti_pkg.sv
package bti_pkg;
  localparam int EN_POS   = 0;
  localparam int PEND_POS = 1;

  typedef struct packed {
    logic pend;
    logic en;
  } bti_mask_t;
endpackage

// File: rtl/bti_host_wr.sv
module bti_host_wr
  import bti_pkg::*;
(
  input  bti_mask_t cur,
  input  logic [1:0] wbits,
  input  logic       atn_any,
  output bti_mask_t  nxt
);
  bti_mask_t mid;

  always_comb begin
    mid = cur;
    if (wbits[EN_POS] != cur.en) begin
      if (wbits[EN_POS]) begin
        if (atn_any) mid.pend = 1'b1;
        mid.en = 1'b1;
      end else begin
        mid.pend = 1'b0;
        mid.en   = 1'b0;
      end
    end
    nxt = mid;
    // acknowledge is judged against the pending bit after the enable step
    if (wbits[PEND_POS] && mid.pend) nxt.pend = 1'b0;
  end
endmodule

// File: rtl/bti_side_evt.sv
module bti_side_evt
  import bti_pkg::*;
(
  input  bti_mask_t cur,
  input  logic      rsp_done,
  input  logic      sms_set,
  input  logic      sms_raise,
  input  logic      sms_clr,
  input  logic      irq_use,
  input  logic      irq_allow,
  input  logic      b2h_atn,
  input  logic      sms_atn,
  output logic      hit,
  output bti_mask_t nxt
);
  logic gate;
  assign gate = irq_use && irq_allow;

  always_comb begin
    nxt = cur;
    hit = rsp_done || sms_set || sms_clr;
    if (rsp_done) begin
      if (gate && cur.en && !cur.pend) nxt.pend = 1'b1;
    end else if (sms_set) begin
      if (!sms_atn && sms_raise && gate && !b2h_atn && cur.en)
        nxt.pend = 1'b1;
    end else if (sms_clr) begin
      if (sms_atn && !b2h_atn) nxt.pend = 1'b0;
    end
  end
endmodule

// File: rtl/bt_host_irq.sv
module bt_host_irq
  import bti_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              rsp_done,
  input  logic              sms_set,
  input  logic              sms_raise,
  input  logic              sms_clr,
  input  logic              rst_req,
  input  logic              rst_cold,
  input  logic              irq_allow,
  input  logic              irq_use,
  input  logic              b2h_atn,
  input  logic              sms_atn,
  output logic              irq,
  output logic [DATA_W-1:0] mask_rd
);
  localparam int PAD_W = DATA_W - 2;

  bti_mask_t mask_q, wr_nxt, side_nxt, mask_d;
  logic      side_hit;
  logic      unused_wdata_hi;

  assign unused_wdata_hi = ^host_wdata[DATA_W-1:2];

  bti_host_wr u_wr (
    .cur     (mask_q),
    .wbits   (host_wdata[1:0]),
    .atn_any (b2h_atn || sms_atn),
    .nxt     (wr_nxt)
  );

  bti_side_evt u_side (
    .cur       (mask_q),
    .rsp_done  (rsp_done),
    .sms_set   (sms_set),
    .sms_raise (sms_raise),
    .sms_clr   (sms_clr),
    .irq_use   (irq_use),
    .irq_allow (irq_allow),
    .b2h_atn   (b2h_atn),
    .sms_atn   (sms_atn),
    .hit       (side_hit),
    .nxt       (side_nxt)
  );

  always_comb begin
    mask_d = mask_q;
    if (rst_req) begin
      if (rst_cold) mask_d = '0;
    end else if (host_wr) begin
      mask_d = wr_nxt;
    end else if (side_hit) begin
      mask_d = side_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  assign irq     = mask_q.pend;
  assign mask_rd = {{PAD_W{1'b0}}, mask_q.pend, mask_q.en};
endmodule

// File: rtl/bt_host_irq_chk.sv
module bt_host_irq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic [DATA_W-1:0] host_wdata,
  input logic              rsp_done,
  input logic              sms_set,
  input logic              sms_clr,
  input logic              rst_req,
  input logic              rst_cold,
  input logic              irq_allow,
  input logic              irq_use,
  input logic              b2h_atn,
  input logic              sms_atn,
  input logic              irq,
  input logic [DATA_W-1:0] mask_rd
);
  logic ev_any, wr_only;
  assign ev_any  = host_wr || rsp_done || sms_set || sms_clr || rst_req;
  assign wr_only = host_wr && !rst_req;

  a_r10_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_any |=> $stable(mask_rd));

  a_r2_enable_raise: assert property (@(posedge clk) disable iff (!rst_n)
    wr_only && host_wdata[0] && !host_wdata[1] && !mask_rd[0] && (b2h_atn || sms_atn)
    |=> irq && mask_rd[0]);

  a_r3_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_only && !host_wdata[0] && mask_rd[0] |=> mask_rd[1:0] == 2'b00);

  a_r4_ack_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    wr_only && host_wdata[1] |=> !irq);

  a_r5_rsp_gated: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done && !host_wr && !rst_req && !(irq_use && irq_allow) |=> $stable(mask_rd));

  a_r8_cold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req && rst_cold |=> mask_rd[1:0] == 2'b00);

  a_r8_warm_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req && !rst_cold |=> $stable(mask_rd));
endmodule

bind bt_host_irq bt_host_irq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
  .rsp_done(rsp_done), .sms_set(sms_set), .sms_clr(sms_clr),
  .rst_req(rst_req), .rst_cold(rst_cold), .irq_allow(irq_allow),
  .irq_use(irq_use), .b2h_atn(b2h_atn), .sms_atn(sms_atn),
  .irq(irq), .mask_rd(mask_rd)
);

// File: tb/tb_bt_host_irq.sv
module tb_bt_host_irq;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic host_wr = 0, rsp_done = 0, sms_set = 0, sms_raise = 0, sms_clr = 0;
  logic rst_req = 0, rst_cold = 0, irq_allow = 0, irq_use = 0, b2h_atn = 0, sms_atn = 0;
  logic [DW-1:0] host_wdata = '0;
  logic irq;
  logic [DW-1:0] mask_rd;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bt_host_irq #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .rsp_done(rsp_done), .sms_set(sms_set), .sms_raise(sms_raise), .sms_clr(sms_clr),
    .rst_req(rst_req), .rst_cold(rst_cold), .irq_allow(irq_allow), .irq_use(irq_use),
    .b2h_atn(b2h_atn), .sms_atn(sms_atn), .irq(irq), .mask_rd(mask_rd)
  );

  task automatic chk(input logic [1:0] exp, input string req);
    n_chk++;
    if (mask_rd !== {{(DW-2){1'b0}}, exp} || irq !== exp[1]) begin
      n_err++;
      $display("FAIL %s: mask_rd=%0h irq=%0b expected mask_rd=%0h irq=%0b",
               req, mask_rd, irq, exp, exp[1]);
    end
  endtask

  task automatic clear_strobes();
    host_wr = 0; rsp_done = 0; sms_set = 0; sms_clr = 0; rst_req = 0;
  endtask

  task automatic wr(input logic [1:0] d);
    @(negedge clk); host_wr = 1; host_wdata = {{(DW-2){1'b0}}, d};
    @(negedge clk); clear_strobes();
  endtask

  task automatic rsp();
    @(negedge clk); rsp_done = 1;
    @(negedge clk); clear_strobes();
  endtask

  task automatic sset(input logic raise);
    @(negedge clk); sms_set = 1; sms_raise = raise;
    @(negedge clk); clear_strobes();
  endtask

  task automatic sclr();
    @(negedge clk); sms_clr = 1;
    @(negedge clk); clear_strobes();
  endtask

  task automatic rreq(input logic cold);
    @(negedge clk); rst_req = 1; rst_cold = cold;
    @(negedge clk); clear_strobes();
  endtask

  task automatic t_reset();
    chk(2'b00, "R1 reset state");
  endtask

  task automatic t_enable();
    b2h_atn = 0; sms_atn = 0;
    wr(2'b01); chk(2'b01, "R2 enable without attention");
    wr(2'b00); chk(2'b00, "R3 disable");
    b2h_atn = 1; irq_use = 0; irq_allow = 0;
    wr(2'b01); chk(2'b11, "R2 enable with attention ignores gates");
    b2h_atn = 0;
    @(negedge clk); chk(2'b11, "R10 attention change alone");
    wr(2'b01); chk(2'b11, "R4 no-op write");
    wr(2'b11); chk(2'b01, "R4 acknowledge");
    wr(2'b00);
    sms_atn = 1;
    wr(2'b11); chk(2'b01, "R4 enable then ack in one write");
    sms_atn = 0;
  endtask

  task automatic t_rsp();
    irq_use = 0; irq_allow = 1;
    rsp(); chk(2'b01, "R5 blocked by use bit");
    irq_use = 1; irq_allow = 0;
    rsp(); chk(2'b01, "R5 blocked by allow");
    irq_allow = 1;
    rsp(); chk(2'b11, "R5 raise");
    wr(2'b00); chk(2'b00, "R3 disable clears pending");
    rsp(); chk(2'b00, "R5 blocked by enable");
    wr(2'b01);
  endtask

  task automatic t_sms();
    b2h_atn = 0; sms_atn = 0;
    sset(0); chk(2'b01, "R6 no raise request");
    b2h_atn = 1;
    sset(1); chk(2'b01, "R6 blocked by b2h attention");
    b2h_atn = 0;
    sset(1); chk(2'b11, "R6 raise");
    wr(2'b11);
    sms_atn = 1;
    sset(1); chk(2'b01, "R6 already set no effect");
    rsp();
    b2h_atn = 1;
    sclr(); chk(2'b11, "R7 kept by b2h attention");
    b2h_atn = 0; sms_atn = 0;
    sclr(); chk(2'b11, "R7 flag already clear");
    sms_atn = 1;
    sclr(); chk(2'b01, "R7 clear lowers");
    sms_atn = 0;
  endtask

  task automatic t_rstrobe();
    rsp();
    rreq(0); chk(2'b11, "R8 warm reset keeps");
    rreq(1); chk(2'b00, "R8 cold reset clears");
  endtask

  task automatic t_priority();
    wr(2'b01);
    @(negedge clk); host_wr = 1; host_wdata = '0; rsp_done = 1;
    @(negedge clk); clear_strobes(); chk(2'b00, "R9 write beats response");
    wr(2'b01); rsp();
    @(negedge clk); rst_req = 1; rst_cold = 1; host_wr = 1; host_wdata = 8'h01;
    @(negedge clk); clear_strobes(); chk(2'b00, "R9 cold reset beats write");
    wr(2'b01);
    sms_atn = 1; b2h_atn = 0;
    @(negedge clk); rsp_done = 1; sms_clr = 1;
    @(negedge clk); clear_strobes(); chk(2'b11, "R9 response beats clear");
    sms_atn = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_rsp();
    t_sms();
    t_rstrobe();
    t_priority();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule